// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit Processor

This block carries an 8-bit processor from the end of one instruction into an interrupt handler. It takes two request lines: a non-maskable request that fires on a falling edge, and a maskable request that is active while it is held low. It also takes the processor's program counter, stack pointer and status byte. When the processor signals an instruction boundary with `poll` and a request is eligible, the block takes a copy of that state. It then runs a fixed seven-cycle bus sequence. That sequence performs two idle reads at the program counter, pushes the return address and the status byte onto the stack page, and fetches the handler address from the vector pair that belongs to the request.

When the sequence ends, the block presents the handler address, the reduced stack pointer and the updated status byte. It pulses `done` in the first cycle in which these values are valid. The processor loads them at that strobe. The memory must return read data combinationally in the same cycle that the address is presented.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0 and `cyc_out` is 0.
- R2: A falling edge on `nmi_n` is latched until it is serviced, and an entry starts only in a cycle with `poll` high while the block is idle. Holding `nmi_n` low produces exactly one entry.
- R3: A maskable request (`irq_n` low) is taken only when the mask bit, status bit 2, is clear in `p_in` in the poll cycle. Otherwise no entry starts.
- R4: When a latched non-maskable request and an eligible maskable request are both present at a poll, the non-maskable request is serviced first.
- R5: An entry occupies exactly seven bus cycles: two reads at the saved program counter, three writes, then two vector reads. `done` is high for exactly one cycle, the cycle after the seventh, and `cyc_out` then reads 7.
- R6: The writes go to page 0x01. The first write puts PC[15:8] at {0x01,SP}, the second puts PC[7:0] at {0x01,SP-1}, and the third puts the status byte at {0x01,SP-2}. The stack pointer arithmetic wraps within 8 bits. No write occurs outside an entry.
- R7: The status byte that is pushed equals `p_in` with bit 4 (the break flag) forced to 0.
- R8: `p_out` equals `p_in` with bit 3 (the decimal flag) cleared. For a maskable entry, bit 2 is also set. For a non-maskable entry, bit 2 is unchanged.
- R9: A non-maskable entry reads the low handler byte at 0xFFFA and the high byte at 0xFFFB. A maskable entry reads 0xFFFE and then 0xFFFF. `pc_out` is {high byte, low byte}.
- R10: `sp_out` equals `sp_in` minus 3, modulo 256.
- R11: Changes on `poll`, `pc_in`, `sp_in` and `p_in` during an entry have no effect on that entry's bus cycles or results, and they start no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | Instruction boundary; an entry may start in this cycle |
| nmi_n | input | 1 | Non-maskable request, falling-edge active |
| irq_n | input | 1 | Maskable request, low-level active |
| pc_in | input | 16 | Program counter at the boundary |
| sp_in | input | 8 | Stack pointer at the boundary |
| p_in | input | 8 | Status byte at the boundary |
| mem_addr | output | 16 | Bus address |
| mem_we | output | 1 | Bus write enable |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid in the same cycle |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle strobe: new state valid |
| pc_out | output | 16 | Handler address |
| sp_out | output | 8 | Stack pointer after the pushes |
| p_out | output | 8 | Status byte after entry |
| cyc_out | output | 3 | Cycles elapsed in the current or last entry |

## Verification
The assertions check the local rules on every cycle. They confirm that writes stay on the stack page and only occur while busy, and that the pushed status byte never carries the break flag. They also confirm that `done` is single-cycle, reads a count of 7 and never shows the decimal flag, that the second vector read is in the top page, and that a maskable entry only begins after an unmasked poll. The scenarios are the only way to show the ordered content of the pushes, the stack wrap, the handler address assembled from the vector bytes, and the priority between simultaneous requests. They also cover the one-entry-per-edge rule for a held line and the immunity of a running entry to input changes.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DUM0, ST_DUM1, ST_PCH, ST_PCL, ST_PSW, ST_VLO, ST_VHI
  } step_e;
  localparam int ENTRY_CYCLES = 7;
  localparam int CNT_W        = $clog2(ENTRY_CYCLES + 1);
  localparam int FLAG_I       = 2;
  localparam int FLAG_D       = 3;
  localparam int FLAG_B       = 4;
endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  input  logic idle,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_mask,
  output logic start,
  output logic take_nmi
);
  logic nmi_prev, nmi_pend, nmi_fall, nmi_avail, irq_avail;

  assign nmi_fall  = nmi_prev & ~nmi_n;
  assign nmi_avail = nmi_pend | nmi_fall;
  assign irq_avail = ~irq_n & ~irq_mask;
  assign take_nmi  = nmi_avail;
  assign start     = poll & idle & (nmi_avail | irq_avail);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= nmi_avail & ~(start & take_nmi);
    end
  end

  // R2: a latched edge survives until an entry consumes it
  assert_pend_held_R2: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !start) |=> nmi_pend);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm #(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    take_nmi,
  input  logic [2*DATA_W-1:0]     pc_in,
  input  logic [DATA_W-1:0]       sp_in,
  input  logic [DATA_W-1:0]       p_in,
  output logic [2*DATA_W-1:0]     mem_addr,
  output logic                    mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic                    svc_nmi,
  output logic [2*DATA_W-1:0]     pc_out,
  output logic [DATA_W-1:0]       sp_out,
  output logic [DATA_W-1:0]       p_out,
  output logic [irq_entry_pkg::CNT_W-1:0] cyc_out
);
  import irq_entry_pkg::*;
  localparam int AW = 2 * DATA_W;

  step_e             step;
  logic [AW-1:0]     pc_s;
  logic [DATA_W-1:0] sp_s, p_s, vlo;
  logic [AW-1:0]     vec_base;

  assign busy     = (step != ST_IDLE);
  assign vec_base = svc_nmi ? NMI_VEC : IRQ_VEC;

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= ST_IDLE;
      pc_s      <= '0;
      sp_s      <= '0;
      p_s       <= '0;
      vlo       <= '0;
      svc_nmi   <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      pc_out    <= '0;
      sp_out    <= '0;
      p_out     <= '0;
      cyc_out   <= '0;
    end else begin
      done <= 1'b0;
      if (step != ST_IDLE) cyc_out <= cyc_out + 1'b1;
      unique case (step)
        ST_IDLE: if (start) begin
          pc_s     <= pc_in;
          sp_s     <= sp_in;
          p_s      <= p_in;
          svc_nmi  <= take_nmi;
          cyc_out  <= '0;
          mem_addr <= pc_in;
          mem_we   <= 1'b0;
          step     <= ST_DUM0;
        end
        ST_DUM0: begin
          mem_addr <= pc_s;
          step     <= ST_DUM1;
        end
        ST_DUM1: begin
          mem_we    <= 1'b1;
          mem_addr  <= {STACK_PAGE, sp_s};
          mem_wdata <= pc_s[AW-1:DATA_W];
          sp_s      <= sp_s - 1'b1;
          step      <= ST_PCH;
        end
        ST_PCH: begin
          mem_addr  <= {STACK_PAGE, sp_s};
          mem_wdata <= pc_s[DATA_W-1:0];
          sp_s      <= sp_s - 1'b1;
          step      <= ST_PCL;
        end
        ST_PCL: begin
          mem_addr  <= {STACK_PAGE, sp_s};
          mem_wdata <= p_s & ~(DATA_W'(1) << FLAG_B);
          sp_s      <= sp_s - 1'b1;
          step      <= ST_PSW;
        end
        ST_PSW: begin
          mem_we   <= 1'b0;
          mem_addr <= vec_base;
          step     <= ST_VLO;
        end
        ST_VLO: begin
          vlo      <= mem_rdata;
          mem_addr <= vec_base + 1'b1;
          step     <= ST_VHI;
        end
        ST_VHI: begin
          pc_out <= {mem_rdata, vlo};
          sp_out <= sp_s;
          p_out  <= (p_s & ~(DATA_W'(1) << FLAG_D))
                    | (svc_nmi ? '0 : (DATA_W'(1) << FLAG_I));
          done   <= 1'b1;
          step   <= ST_IDLE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

  // R6: every write lands on the stack page, and only during an entry
  assert_we_page_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:DATA_W] == STACK_PAGE) && busy);
  // R7: the pushed status byte never carries the break flag
  assert_push_nob_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && step == ST_PSW) |-> !mem_wdata[FLAG_B]);
  // R5: done is a single-cycle strobe
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: completion always reports seven cycles
  assert_done_count_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_out == CNT_W'(ENTRY_CYCLES)));
  // R8: decimal flag is cleared on completion
  assert_dclr_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !p_out[FLAG_D]);
  // R9: second vector read is in the top page
  assert_vec_page_R9: assert property (@(posedge clk) disable iff (rst)
    (step == ST_VHI) |-> (mem_addr[AW-1:DATA_W] == '1));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 poll,
  input  logic                 nmi_n,
  input  logic                 irq_n,
  input  logic [2*DATA_W-1:0]  pc_in,
  input  logic [DATA_W-1:0]    sp_in,
  input  logic [DATA_W-1:0]    p_in,
  output logic [2*DATA_W-1:0]  mem_addr,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [2*DATA_W-1:0]  pc_out,
  output logic [DATA_W-1:0]    sp_out,
  output logic [DATA_W-1:0]    p_out,
  output logic [irq_entry_pkg::CNT_W-1:0] cyc_out
);
  import irq_entry_pkg::*;

  logic start, take_nmi, svc_nmi;

  irq_req_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .poll     (poll),
    .idle     (~busy),
    .nmi_n    (nmi_n),
    .irq_n    (irq_n),
    .irq_mask (p_in[FLAG_I]),
    .start    (start),
    .take_nmi (take_nmi)
  );

  irq_entry_fsm #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .NMI_VEC    (NMI_VEC),
    .IRQ_VEC    (IRQ_VEC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .take_nmi  (take_nmi),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .p_in      (p_in),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .svc_nmi   (svc_nmi),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .p_out     (p_out),
    .cyc_out   (cyc_out)
  );

  // R3: a maskable entry only follows an unmasked, asserted, polled request
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !svc_nmi) |-> $past(poll && !irq_n && !p_in[FLAG_I]));
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic clk = 1'b0, rst = 1'b1, poll = 1'b0, nmi_n = 1'b1, irq_n = 1'b1;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0, p_in = '0;
  logic [15:0] mem_addr, pc_out;
  logic        mem_we, busy, done;
  logic [7:0]  mem_wdata, sp_out, p_out;
  logic [7:0]  mem_rdata;
  logic [2:0]  cyc_out;
  logic [7:0]  vnl = 8'h34, vnh = 8'h12, vil = 8'hCD, vih = 8'hAB;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .poll(poll), .nmi_n(nmi_n), .irq_n(irq_n),
    .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out), .cyc_out(cyc_out)
  );

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = vnl;
      16'hFFFB: mem_rdata = vnh;
      16'hFFFE: mem_rdata = vil;
      16'hFFFF: mem_rdata = vih;
      default:  mem_rdata = mem_addr[7:0] ^ mem_addr[15:8];
    endcase
  end

  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;
  typedef struct packed { logic [15:0] pc0; logic [15:0] va; logic [15:0] pcn;
                          logic [7:0] spn; logic [7:0] pn; } res_t;
  wr_t  wr_q[$];
  res_t res_q[$];
  int   n_chk = 0, n_bad = 0, starts = 0, exp_starts = 0, bc = 0;
  logic busy_d = 1'b0;
  bit   nmi_pm = 1'b0, fin = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: a poll at the given state, expectations pushed into the queues
  task automatic do_poll(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p,
                         input bit disturb);
    bit nm, iq;
    res_t r;
    @(negedge clk);
    pc_in = pc; sp_in = sp; p_in = p; poll = 1'b1;
    nm = nmi_pm;
    iq = !nm && !irq_n && !p[2];
    if (nm || iq) begin
      if (nm) nmi_pm = 1'b0;
      exp_starts++;
      wr_q.push_back('{a: {8'h01, sp}, d: pc[15:8]});
      wr_q.push_back('{a: {8'h01, 8'(sp - 8'd1)}, d: pc[7:0]});
      wr_q.push_back('{a: {8'h01, 8'(sp - 8'd2)}, d: p & 8'hEF});
      r.pc0 = pc;
      r.va  = nm ? 16'hFFFA : 16'hFFFE;
      r.pcn = nm ? {vnh, vnl} : {vih, vil};
      r.spn = sp - 8'd3;
      r.pn  = (p & 8'hF7) | (iq ? 8'h04 : 8'h00);
      res_q.push_back(r);
    end
    @(negedge clk);
    poll = 1'b0;
    if (disturb) begin
      @(negedge clk);
      pc_in = 16'hFFFF; sp_in = 8'h00; p_in = 8'hFF; poll = 1'b1;
      @(negedge clk);
      poll = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic nmi_edge();
    @(negedge clk);
    nmi_n = 1'b1;
    @(negedge clk);
    nmi_n = 1'b0;
    nmi_pm = 1'b1;
  endtask

  // monitor: pops and compares as the design produces bus cycles and results
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !busy_d) starts++;
      busy_d = busy;
      if (busy) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R2 unexpected entry", 32'(busy), 32'd0);
        end else begin
          case (bc)
            0, 1: chk(!mem_we && mem_addr == res_q[0].pc0, "R5 idle read at PC",
                      {15'd0, mem_we, mem_addr}, {16'd0, res_q[0].pc0});
            2, 3, 4: begin
              chk(mem_we, "R5 write cycle", 32'(mem_we), 32'd1);
              if (wr_q.size() != 0) begin
                wr_t w;
                w = wr_q.pop_front();
                chk(mem_addr == w.a, "R6 push address", 32'(mem_addr), 32'(w.a));
                if (bc == 4) chk(mem_wdata == w.d, "R7 pushed status", 32'(mem_wdata), 32'(w.d));
                else         chk(mem_wdata == w.d, "R6 pushed PC byte", 32'(mem_wdata), 32'(w.d));
              end
            end
            5: chk(!mem_we && mem_addr == res_q[0].va, "R9 vector low address",
                   32'(mem_addr), 32'(res_q[0].va));
            6: chk(!mem_we && mem_addr == res_q[0].va + 16'd1, "R9 vector high address",
                   32'(mem_addr), 32'(res_q[0].va + 16'd1));
            default: chk(1'b0, "R5 entry too long", 32'(bc), 32'd6);
          endcase
        end
        bc++;
      end else if (mem_we) begin
        chk(1'b0, "R6 write outside entry", 32'(mem_addr), 32'd0);
      end
      if (done) begin
        chk(bc == 7, "R5 busy length", 32'(bc), 32'd7);
        chk(cyc_out == 3'd7, "R5 cycle count", 32'(cyc_out), 32'd7);
        if (res_q.size() != 0) begin
          res_t r;
          r = res_q.pop_front();
          chk(pc_out == r.pcn, "R9 handler address", 32'(pc_out), 32'(r.pcn));
          chk(sp_out == r.spn, "R10 stack pointer", 32'(sp_out), 32'(r.spn));
          chk(p_out == r.pn, "R8 status after entry", 32'(p_out), 32'(r.pn));
        end else begin
          chk(1'b0, "R5 done without entry", 32'(done), 32'd0);
        end
        bc = 0;
      end
    end
  end

  task automatic finish_run();
    chk(starts == exp_starts, "R2 R11 R3 entry count", 32'(starts), 32'(exp_starts));
    chk(wr_q.size() == 0 && res_q.size() == 0, "R5 leftover expectations",
        32'(wr_q.size() + res_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    fin = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    chk(!busy && !done && !mem_we && cyc_out == 3'd0, "R1 reset state",
        {28'd0, busy, done, mem_we, 1'b0}, 32'd0);

    // maskable entry, break and decimal flags set on input: R3 R7 R8
    irq_n = 1'b0;
    do_poll(16'h1234, 8'hFF, 8'h3B, 1'b0);
    // mask bit set: no entry (R3)
    do_poll(16'h2222, 8'hF0, 8'h04, 1'b0);
    irq_n = 1'b1;

    // non-maskable entry with stack wrap: R6 R9 R10
    nmi_edge();
    do_poll(16'hABCD, 8'h01, 8'hDC, 1'b0);
    // line still held low: no second entry (R2)
    do_poll(16'h3333, 8'h80, 8'h00, 1'b0);

    // both pending: non-maskable first, then maskable (R4)
    vnl = 8'h9A; vnh = 8'h78; vil = 8'h11; vih = 8'hC0;
    nmi_edge();
    irq_n = 1'b0;
    do_poll(16'h4444, 8'h40, 8'h20, 1'b0);
    do_poll(16'h5555, 8'h3D, 8'h21, 1'b0);
    irq_n = 1'b1;

    // inputs and poll change mid-entry: R11
    nmi_edge();
    do_poll(16'h0F0F, 8'h02, 8'h08, 1'b1);

    // no request at all: no entry
    nmi_n = 1'b1;
    do_poll(16'h6666, 8'h10, 8'h00, 1'b0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule